// File: doc/BRIEF.md
# PWM Compare Reload Controller

This block keeps two copies of each of the seven registers that drive a three-phase, center-aligned PWM timer. The timer reads the active copy. Software writes the staging copy through a single-cycle write port. The registers are the carrier period, three phase duty values, an interrupt-thinning setting, and two converter-trigger timing values. A mode-control word at its own address selects when staging values become active.

In immediate mode, each write goes straight to the active copy of the addressed register. In the two batch modes, a write to the phase-U duty register arms the block. The next counter peak (counter equal to the active period) or trough (counter equal to 1) then copies all seven staging values into the active copies in a single cycle. In the culled batch mode, only the peaks and troughs that an external interrupt-thinning unit lets through can perform the copy. That unit reports them on a strobe input.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, every staging copy and every active copy reads zero, the armed flag is clear, and the mode is plain batch.
- R2: The register addresses are 0 period, 1 phase-U duty, 2 phase-V duty, 3 phase-W duty, 4 thinning setting, 5 trigger time A and 6 trigger time B. A write to any of these addresses updates that staging copy from the next cycle, in every mode. Address 7 is the mode word: bit 0 selects immediate mode, and bit 1 selects culled batch mode when bit 0 is clear.
- R3: In immediate mode, a write to addresses 0 to 6 sets the active copy of that register from the next cycle and leaves the other active copies unchanged. Bit 1 of the mode word has no effect in this mode, and the armed flag stays clear.
- R4: In either batch mode, a write to address 1 sets the armed flag from the next cycle. Writes to any other address leave the armed flag as it was.
- R5: A transfer event is a cycle in which the counter equals the active period or equals 1. In plain batch mode every event counts, whatever the thinning strobe or the thinning setting holds.
- R6: An event that arrives while the block is armed copies all seven staging values, as they stood before that clock edge, into the active copies. The new values are visible from the next cycle, and the armed flag clears.
- R7: In culled batch mode, an event counts only when the thinning strobe is high in the same cycle. An event without the strobe changes neither the active copies nor the armed flag.
- R8: In the batch modes, the active copies do not change in any cycle that is not an armed event.
- R9: If a write to address 1 falls in the same cycle as an armed event, the transfer uses the older phase-U staging value. The block stays armed afterwards, and the newer value is copied at the following event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DW | Register write data |
| counter | input | DW | Current value of the triangle counter |
| cullPass | input | 1 | High when the current peak or trough survives thinning |
| stageFlat | output | 7*DW | Staging copies, register i at bits [i*DW +: DW] |
| activeFlat | output | 7*DW | Active copies, same packing |
| armed | output | 1 | A batch transfer is pending |

## Verification
A wrong armed flag shows up on `armed` in the cycle after the write or event that caused it. It also shows on `activeFlat` at the next event, where a lost transfer or an extra transfer changes all seven fields together. A wrong event decode, such as a peak compared against the staging period or a thinning strobe that is ignored, shows as an active copy that updates one event early or late. The bench moves the counter across every value in and near the period and toggles the strobe, so these faults appear within a few cycles of the event concerned.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int NUM_REGS   = 7;
  localparam int ADDR_W     = 3;
  localparam int IDX_PERIOD = 0;
  localparam int IDX_TRIG   = 1;
  localparam int ADDR_MODE  = 7;

  typedef struct packed {
    logic [NUM_REGS-1:0] stageWe;
    logic [NUM_REGS-1:0] activeWe;
    logic                bulkLoad;
  } reload_strobe_t;
endpackage

// File: rtl/pwm_reload_seq.sv
module pwm_reload_seq
  import pwm_reload_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        modeData,
  input  logic [DW-1:0]     counter,
  input  logic [DW-1:0]     activePeriod,
  input  logic              cullPass,
  output reload_strobe_t    strobe,
  output logic              armed,
  output logic              immMode,
  output logic              xferEvt
);
  logic cullEn;
  logic peakHit;
  logic troughHit;
  logic trigWr;
  logic [NUM_REGS-1:0] addrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      immMode <= 1'b0;
      cullEn  <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_W'(ADDR_MODE)) begin
      immMode <= modeData[0];
      cullEn  <= modeData[1];
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_dec
      assign addrHit[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    peakHit   = (counter == activePeriod);
    troughHit = (counter == DW'(1));
    xferEvt   = !immMode && (peakHit || troughHit) && (!cullEn || cullPass);
    trigWr    = addrHit[IDX_TRIG] && !immMode;
    strobe.stageWe  = addrHit;
    strobe.activeWe = immMode ? addrHit : '0;
    strobe.bulkLoad = armed && xferEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (immMode) begin
      armed <= 1'b0;
    end else begin
      armed <= (armed && !xferEvt) || trigWr;
    end
  end
endmodule

// File: rtl/pwm_reload_regs.sv
module pwm_reload_regs
  import pwm_reload_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  reload_strobe_t         strobe,
  input  logic [DW-1:0]          wrData,
  output logic [NUM_REGS*DW-1:0] stageFlat,
  output logic [NUM_REGS*DW-1:0] activeFlat,
  output logic [DW-1:0]          activePeriod
);
  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DW-1:0] stg;
      logic [DW-1:0] act;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stg <= '0;
        end else if (strobe.stageWe[i]) begin
          stg <= wrData;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          act <= '0;
        end else if (strobe.activeWe[i]) begin
          act <= wrData;
        end else if (strobe.bulkLoad) begin
          act <= stg;
        end
      end

      assign stageFlat[i*DW +: DW]  = stg;
      assign activeFlat[i*DW +: DW] = act;
    end
  endgenerate

  assign activePeriod = activeFlat[IDX_PERIOD*DW +: DW];
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DW-1:0]          wrData,
  input  logic [DW-1:0]          counter,
  input  logic                   cullPass,
  output logic [NUM_REGS*DW-1:0] stageFlat,
  output logic [NUM_REGS*DW-1:0] activeFlat,
  output logic                   armed
);
  reload_strobe_t strobe;
  logic [DW-1:0]  activePeriod;
  logic           immMode;
  logic           xferEvt;

  pwm_reload_seq #(.DW(DW)) u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .modeData     (wrData[1:0]),
    .counter      (counter),
    .activePeriod (activePeriod),
    .cullPass     (cullPass),
    .strobe       (strobe),
    .armed        (armed),
    .immMode      (immMode),
    .xferEvt      (xferEvt)
  );

  pwm_reload_regs #(.DW(DW)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .stageFlat    (stageFlat),
    .activeFlat   (activeFlat),
    .activePeriod (activePeriod)
  );
endmodule

// File: rtl/pwm_reload_checker.sv
module pwm_reload_checker
  import pwm_reload_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      wrAddr,
  input logic [DW-1:0]          wrData,
  input logic [NUM_REGS*DW-1:0] stageFlat,
  input logic [NUM_REGS*DW-1:0] activeFlat,
  input logic                   armed,
  input logic                   immMode,
  input logic                   xferEvt
);
  function automatic logic [DW-1:0] pick(input logic [NUM_REGS*DW-1:0] f, input logic [ADDR_W-1:0] idx);
    return f[int'(idx)*DW +: DW];
  endfunction

  p_imm_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (immMode && wrEn && wrAddr != ADDR_W'(ADDR_MODE)) |=> (pick(activeFlat, $past(wrAddr)) == $past(wrData)));

  p_imm_noarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    immMode |=> !armed);

  p_trig_arms_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!immMode && wrEn && wrAddr == ADDR_W'(IDX_TRIG)) |=> armed);

  p_bulk_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!immMode && armed && xferEvt) |=> (activeFlat == $past(stageFlat)));

  p_clear_after_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!immMode && armed && xferEvt && !(wrEn && wrAddr == ADDR_W'(IDX_TRIG))) |=> !armed);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!immMode && !(armed && xferEvt)) |=> $stable(activeFlat));
endmodule

bind pwm_reload_ctrl pwm_reload_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .stageFlat  (stageFlat),
  .activeFlat (activeFlat),
  .armed      (armed),
  .immMode    (immMode),
  .xferEvt    (xferEvt)
);

// File: tb/pwm_reload_ctrl_test.sv
module pwm_reload_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NR = 7;
  localparam logic [DW-1:0] IDLE = 16'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] counter = IDLE;
  logic cullPass = 1'b0;
  logic [NR*DW-1:0] stageFlat;
  logic [NR*DW-1:0] activeFlat;
  logic armed;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  logic [DW-1:0] expStage [NR];
  logic [DW-1:0] expAct [NR];
  logic expArmed;
  logic mImm;
  logic mCull;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_ctrl #(.DW(DW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .counter(counter), .cullPass(cullPass),
    .stageFlat(stageFlat), .activeFlat(activeFlat), .armed(armed)
  );

  task automatic compareAll(input string tag);
    string msg;
    bit bad;
    bad = 0;
    msg = "";
    testCount++;
    for (int i = 0; i < NR; i++) begin
      if (!bad && stageFlat[i*DW +: DW] !== expStage[i]) begin
        bad = 1;
        $sformat(msg, "staging[%0d] actual %h expected %h", i, stageFlat[i*DW +: DW], expStage[i]);
      end
      if (!bad && activeFlat[i*DW +: DW] !== expAct[i]) begin
        bad = 1;
        $sformat(msg, "active[%0d] actual %h expected %h", i, activeFlat[i*DW +: DW], expAct[i]);
      end
    end
    if (!bad && armed !== expArmed) begin
      bad = 1;
      $sformat(msg, "armed actual %b expected %b", armed, expArmed);
    end
    if (bad) begin
      failCount++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Drive inputs at negedge, advance model at posedge, check at next negedge.
  task automatic step(input logic we, input logic [2:0] a, input logic [DW-1:0] d,
                      input logic [DW-1:0] cnt, input logic cull, input string tag);
    logic evt;
    logic [DW-1:0] oldStage [NR];
    wrEn = we; wrAddr = a; wrData = d; counter = cnt; cullPass = cull;
    @(posedge clk);
    evt = !mImm && ((cnt == expAct[0]) || (cnt == 16'd1)) && (!mCull || cull);
    for (int i = 0; i < NR; i++) oldStage[i] = expStage[i];
    if (we && a < 3'd7) begin
      expStage[a] = d;
      if (mImm) expAct[a] = d;
    end
    if (expArmed && evt)
      for (int i = 0; i < NR; i++) expAct[i] = oldStage[i];
    if (mImm) expArmed = 1'b0;
    else expArmed = (expArmed && !evt) || (we && a == 3'd1);
    if (we && a == 3'd7) begin
      mImm = d[0];
      mCull = d[1];
    end
    @(negedge clk);
    wrEn = 1'b0;
    compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin expStage[i] = '0; expAct[i] = '0; end
    expArmed = 0; mImm = 0; mCull = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1 reset");

    // R2/R4/R8: stage all registers except trigger, no arming, active held
    step(1, 3'd0, 16'h0040, IDLE, 0, "R2 period staged");
    for (int a = 2; a < NR; a++) step(1, 3'(a), 16'h0100 + 16'(a), IDLE, 0, "R4 non-trigger write");
    step(0, 3'd0, 16'h0, IDLE, 1, "R8 idle unarmed");
    step(0, 3'd0, 16'h0, 16'd1, 0, "R8 trough unarmed");
    step(1, 3'd1, 16'h0011, IDLE, 0, "R4 trigger arms");
    step(0, 3'd0, 16'h0, IDLE, 0, "R8 armed no event");
    step(0, 3'd0, 16'h0, 16'd1, 0, "R6 trough transfer");

    // R5: sweep counter around the period with re-arming each time
    for (int c = 0; c < 16'h0048; c++) begin
      step(1, 3'd1, 16'h2000 + 16'(c), IDLE, 0, "R4 rearm");
      step(0, 3'd0, 16'h0, 16'(c), c[0], "R5 sweep batch");
    end

    // R9: trigger write coincident with a peak
    step(1, 3'd1, 16'h0AAA, IDLE, 0, "R4 arm");
    step(1, 3'd1, 16'h0BBB, 16'h0040, 0, "R9 coincident write");
    step(0, 3'd0, 16'h0, 16'd1, 0, "R9 following event");

    // R5: nonzero thinning setting ignored in plain batch mode
    step(1, 3'd4, 16'h001F, IDLE, 0, "R2 thinning staged");
    step(1, 3'd1, 16'h0C0C, IDLE, 0, "R4 arm");
    step(0, 3'd0, 16'h0, 16'h0040, 0, "R5 batch ignores strobe");

    // R7: culled batch mode
    step(1, 3'd7, 16'h0002, IDLE, 0, "R2 mode culled");
    for (int c = 0; c < 16'h0044; c++) begin
      for (int s = 0; s < 2; s++) begin
        step(1, 3'd1, 16'h3000 + 16'(c*2+s), IDLE, 0, "R4 rearm culled");
        step(1, 3'd5, 16'h5000 + 16'(c), 16'(c), s[0], "R7 sweep culled");
      end
    end

    // R3: immediate mode, reload-enable bit clear and set
    for (int m = 1; m < 4; m += 2) begin
      step(1, 3'd7, 16'(m), IDLE, 0, "R2 mode immediate");
      for (int a = 0; a < NR; a++) begin
        step(1, 3'(a), 16'h7000 + 16'(m*16 + a), IDLE, 0, "R3 immediate write");
        step(0, 3'd0, 16'h0, 16'd1, 1, "R3 no event effect");
      end
    end

    // Back to batch: trigger works again
    step(1, 3'd7, 16'h0000, IDLE, 0, "R2 mode batch");
    step(1, 3'd2, 16'h0E0E, IDLE, 0, "R8 staged only");
    step(1, 3'd1, 16'h0D0D, IDLE, 0, "R4 arm again");
    step(0, 3'd0, 16'h0, 16'd1, 0, "R6 final transfer");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule